// File: doc/BRIEF.md
# Smart Shutdown Fault Latch

This block is the digital half of a fast overcurrent shutdown shared by the three phases of an inverter bridge. It watches two asynchronous inputs. The first is the digitised output of a current-sense comparator. The second is the sensed logic level of a shared shutdown line, which is bidirectional: external logic can pull it low, and the block can pull it low through an open-drain transistor. From these it drives two outputs: a pull-down enable for the shutdown line, and a force-off command that reaches every gate driver.

When the comparator trips, the force-off command rises in the same cycle through a combinational path. It does not wait for the slow resistor-capacitor network on the shutdown line to discharge. The block then pulls the line low and holds it there until the line is sensed low. At that point it releases the line and lets the external network recharge it. The gates stay off until the line reads high again. As a result, the total disable time is longer than the network's own time constant.

A sticky fault flag records that a trip happened. It clears only when the clear input is pulsed while the block is idle.

Top module: `fault_shutdown_latch`

## Requirements
- R1: After reset the pull-down enable is 0, the force-off command is 0 and the fault flag is 0.
- R2: A high on the raw trip input raises the force-off command in the same cycle, with no synchroniser delay.
- R3: A trip that stays high turns the pull-down on at the third rising clock edge after it appears. This delay is two synchroniser flops plus one state register.
- R4: The pull-down stays on while the synchronised line level reads 1. It turns off at the third rising edge after the line goes low.
- R5: The force-off command stays high from the trip until the line reads 1 again with no trip present. It falls at the third rising edge after the line returns high.
- R6: An external low on the line with no trip raises the force-off command at the second rising edge. It leaves the pull-down and the fault flag at 0.
- R7: The fault flag sets on the same edge that the pull-down first turns on. It stays set until the clear input is high on a clock edge while the block is idle and the synchronised trip is 0. A clear at any other time has no effect.
- R8: A new trip that arrives while the block waits for the line to recharge turns the pull-down on again at the third rising edge.
- R9: The pull-down is never on while the fault flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_raw_i | input | 1 | Asynchronous comparator trip, 1 = overcurrent |
| pin_raw_i | input | 1 | Asynchronous sensed level of the shared shutdown line, 1 = high |
| clear_i | input | 1 | Clears the fault flag when the block is idle |
| od_pulldown_o | output | 1 | 1 = open-drain pulls the shutdown line low |
| gate_off_o | output | 1 | 1 = all gate drivers forced off |
| fault_flag_o | output | 1 | Sticky record of a trip |

## Verification
The bench targets four kinds of design error:

- **Latency on the fast path.** A design that sent the trip through the synchroniser before force-off would leave the gates on for two cycles during an overcurrent.
- **Early release of the pull-down.** A design that dropped the pull-down as soon as the trip cleared, before the line was sensed low, would shorten the disable time to the network's own constant.
- **Hold and retrip.** The bench releases the line and retrips during recovery. A design that left hold too early would re-enable the gates while the line is still low. A design that ignored the retrip would leave the line floating during a second fault.
- **Clear handling.** The bench pulses clear both mid-fault and in idle. A flag that cleared mid-fault would lose the record of an active trip.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PULL = 2'd1,
    ST_HOLD = 2'd2
  } sdl_state_e;

  // Next-state rule of the shutdown sequencer.
  function automatic sdl_state_e sdl_next(sdl_state_e cur, logic trip, logic line_hi);
    sdl_state_e nxt;
    nxt = cur;
    case (cur)
      ST_IDLE: if (trip) nxt = ST_PULL;
      ST_PULL: if (!line_hi) nxt = ST_HOLD;
      ST_HOLD: begin
        if (trip)         nxt = ST_PULL;
        else if (line_hi) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
    return nxt;
  endfunction

  // Sticky fault flag: a trip sets it; a clear in idle with no trip drops it.
  function automatic logic sdl_flag_next(logic cur, logic trip, logic clr, logic idle);
    if (trip)             return 1'b1;
    else if (clr && idle) return 1'b0;
    else                  return cur;
  endfunction

endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d_i;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain[LAST];
endmodule

// File: rtl/sdl_ctrl.sv
module sdl_ctrl
  import sdl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_s_i,
  input  logic       line_s_i,
  input  logic       clear_i,
  output sdl_state_e state_o,
  output logic       fault_o
);
  sdl_state_e state_q;
  logic       fault_q;
  logic       idle;

  assign idle = (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= 1'b0;
    end else begin
      state_q <= sdl_next(state_q, trip_s_i, line_s_i);
      fault_q <= sdl_flag_next(fault_q, trip_s_i, clear_i, idle);
    end
  end

  assign state_o = state_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/fault_shutdown_latch.sv
module fault_shutdown_latch
  import sdl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_raw_i,
  input  logic pin_raw_i,
  input  logic clear_i,
  output logic od_pulldown_o,
  output logic gate_off_o,
  output logic fault_flag_o
);
  // Named internal events, brought out for the checker.
  logic       trip_s;
  logic       pin_s;
  logic       in_idle;
  sdl_state_e state;

  sdl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_trip_sync (
    .clk(clk), .rst_n(rst_n), .d_i(trip_raw_i), .q_o(trip_s)
  );

  // The line idles high through its external pull-up.
  sdl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_raw_i), .q_o(pin_s)
  );

  sdl_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trip_s_i(trip_s), .line_s_i(pin_s),
    .clear_i(clear_i), .state_o(state), .fault_o(fault_flag_o)
  );

  assign in_idle       = (state == ST_IDLE);
  assign od_pulldown_o = (state == ST_PULL);
  // Fast path: the raw trip bypasses the synchronisers.
  assign gate_off_o    = trip_raw_i | ~in_idle | ~pin_s;
endmodule

// File: rtl/sdl_checker.sv
module sdl_checker (
  input logic clk,
  input logic rst_n,
  input logic trip_raw,
  input logic clear,
  input logic trip_s,
  input logic pin_s,
  input logic in_idle,
  input logic od,
  input logic gate_off,
  input logic fault
);
  a_r2_raw_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
    trip_raw |-> gate_off);

  a_r3_trip_pulls: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_s && !od) |=> od);

  a_r4_pull_held: assert property (@(posedge clk) disable iff (!rst_n)
    (od && pin_s) |=> od);

  a_r4_pull_released: assert property (@(posedge clk) disable iff (!rst_n)
    (od && !pin_s) |=> !od);

  a_r5_off_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_idle || !pin_s) |-> gate_off);

  a_r6_no_pull_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && !trip_s) |=> !od);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !(clear && in_idle)) |=> fault);

  a_r9_pull_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    od |-> fault);
endmodule

bind fault_shutdown_latch sdl_checker u_sdl_checker (
  .clk(clk), .rst_n(rst_n), .trip_raw(trip_raw_i), .clear(clear_i),
  .trip_s(trip_s), .pin_s(pin_s), .in_idle(in_idle),
  .od(od_pulldown_o), .gate_off(gate_off_o), .fault(fault_flag_o)
);

// File: tb/test_fault_shutdown_latch.sv
module test_fault_shutdown_latch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0;
  logic pin = 1'b1;
  logic clr = 1'b0;
  logic od, goff, flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  fault_shutdown_latch i_fault_shutdown_latch (
    .clk(clk), .rst_n(rst_n), .trip_raw_i(trip), .pin_raw_i(pin),
    .clear_i(clr), .od_pulldown_o(od), .gate_off_o(goff), .fault_flag_o(flag)
  );

  // Reference model. Phase codes: 0 idle, 1 pulling the line, 2 waiting for recharge.
  function automatic int ref_phase(int ph, bit t, bit hi);
    if (ph == 0) return t ? 1 : 0;
    if (ph == 1) return hi ? 1 : 2;
    if (t) return 1;
    return hi ? 0 : 2;
  endfunction

  function automatic bit ref_flag(bit f, bit t, bit c, int ph);
    return t | (f & ~(c & (ph == 0)));
  endfunction

  bit t1, t2, p1, p2, mflag;
  int mph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1 <= 0; t2 <= 0; p1 <= 1; p2 <= 1; mph <= 0; mflag <= 0;
    end else begin
      t1 <= trip; t2 <= t1; p1 <= pin; p2 <= p1;
      mph   <= ref_phase(mph, t2, p2);
      mflag <= ref_flag(mflag, t2, clr, mph);
    end
  end

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model, 1 ns after each falling edge.
  always @(negedge clk) begin
    #1;
    if (cmp_on && rst_n) begin
      chk("R4 pulldown", od, mph == 1);
      chk("R5 gate_off", goff, trip | (mph != 0) | ~p2);
      chk("R7 flag", flag, mflag);
    end
  end

  task automatic step(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    int r;
    seed = $urandom(32'd20240611);
    step(3);
    @(negedge clk); rst_n = 1'b1;
    step(1);
    chk("R1 pulldown", od, 1'b0);
    chk("R1 gate_off", goff, 1'b0);
    chk("R1 flag", flag, 1'b0);
    cmp_on = 1'b1;

    // R2 and R3: trip, fast force-off, delayed pull-down.
    @(negedge clk); trip = 1'b1; #1;
    chk("R2 immediate gate_off", goff, 1'b1);
    chk("R2 no pulldown yet", od, 1'b0);
    step(2); chk("R3 pulldown after 2 edges", od, 1'b0);
    step(1); chk("R3 pulldown after 3 edges", od, 1'b1);
    chk("R7 flag on trip", flag, 1'b1);
    @(negedge clk); trip = 1'b0;

    // R4: line held high by the network keeps the pull-down on.
    step(10); chk("R4 pulldown held", od, 1'b1);
    @(negedge clk); pin = 1'b0;
    step(2); chk("R4 pulldown before release", od, 1'b1);
    step(1); chk("R4 pulldown released", od, 1'b0);
    chk("R5 off in hold", goff, 1'b1);

    // R7: a clear outside idle has no effect.
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; #1;
    chk("R7 clear ignored in hold", flag, 1'b1);

    // R8: retrip while waiting for recharge.
    @(negedge clk); trip = 1'b1;
    step(3); chk("R8 pulldown on again", od, 1'b1);
    @(negedge clk); trip = 1'b0;
    step(6);

    // R5: line recharges, gates released at the third edge.
    @(negedge clk); pin = 1'b1;
    step(2); chk("R5 still off", goff, 1'b1);
    step(1); chk("R5 released", goff, 1'b0);

    // R7: a clear in idle drops the flag.
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0; #1;
    chk("R7 cleared in idle", flag, 1'b0);

    // R6: an external low with no trip.
    @(negedge clk); pin = 1'b0; #1;
    chk("R6 not yet off", goff, 1'b0);
    step(2); chk("R6 forced off", goff, 1'b1);
    step(3);
    chk("R6 no pulldown", od, 1'b0);
    chk("R6 no flag", flag, 1'b0);
    @(negedge clk); pin = 1'b1;
    step(4);

    // Random phase: mostly quiet with occasional trips and clears.
    // The line falls with some delay while pulled low.
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      r = int'($urandom % 100);
      if (r < 3) trip = 1'b1;
      else if (r < 20) trip = 1'b0;
      r = int'($urandom % 100);
      if (od && r < 30) pin = 1'b0;
      else if (!od && r < 8) pin = ~pin;
      clr = ($urandom % 100) < 6;
      if (i % 500 == 0) chk("R9 pulldown implies flag", od & ~flag, 1'b0);
    end
    @(negedge clk); trip = 1'b0; clr = 1'b0; pin = 1'b1;
    step(4);
    finish_run();
  end
endmodule